// File: doc/BRIEF.md
# Predicate Compare-and-Define Unit

This block holds a file of single-bit predicates and executes predicate-define operations against it. A define operation compares two 64-bit integer operands under a selected relation. It then writes up to two destination predicates, and each destination follows its own write type. The operation is itself guarded by a qualifying predicate read from the same file. When that predicate is false, the operation is suppressed in a type-dependent way rather than simply dropped.

The predicate values are exposed on combinational read ports. Issue logic elsewhere uses them to nullify instructions: an instruction whose predicate reads 0 has its result discarded, and one whose predicate reads 1 keeps it. Entry 0 is a constant true predicate, so an operation qualified by entry 0 always executes. A define operation is presented for one cycle with `defValid` high. Its writes land on that rising clock edge and are visible on the read ports from then on.

Top module: `predDefUnit`

## Requirements
- R1: After reset, entry 0 reads 1 and every other entry reads 0.
- R2: Entry 0 always reads 1; a write aimed at index 0 leaves it at 1.
- R3: The 3-bit relation code selects: 0 equal, 1 not equal, 2 signed less-than, 3 signed less-or-equal, 4 signed greater-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 reserved (compare result false).
- R4: With the qualifier true, a type-0 (plain) destination receives the compare result and a type-1 (inverted plain) destination receives its inverse.
- R5: With the qualifier true, a type-2 (accumulate) destination is set to 1 when the compare is true and is otherwise left unchanged. A type-3 (inverted accumulate) destination is set to 1 when the compare is false and is otherwise left unchanged.
- R6: With the qualifier false, type-0 and type-1 destinations are written 0 whatever the compare result.
- R7: With the qualifier false, type-2 and type-3 destinations keep their previous value.
- R8: When both destination indices are equal, the second destination's write decides the stored value.
- R9: Writes occur only on a clock edge with `defValid` high and become visible on the read ports after that edge. With `defValid` low, no entry changes.
- R10: The qualifier is the current value of the predicate file entry named by `qualIdx`, including entries set by earlier define operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| defValid | input | 1 | A define operation is presented this cycle |
| relSel | input | 3 | Compare relation code |
| dstIdxA | input | 6 | First destination predicate index |
| dstTypeA | input | 2 | First destination write type |
| dstIdxB | input | 6 | Second destination predicate index |
| dstTypeB | input | 2 | Second destination write type |
| qualIdx | input | 6 | Qualifying predicate index |
| srcA | input | 64 | First compare operand |
| srcB | input | 64 | Second compare operand |
| rdIdx | input | 12 | Read port indices, port k in bits [6k+5:6k] |
| rdVal | output | 2 | Read port values, port k in bit k |

## Verification
The hardest situation to reach is a suppressed operation with a false qualifier. It only means something when the accumulate-type targets already hold 1 and the qualifier entry is a real 0 rather than the constant entry. The stimulus first builds that state through ordinary true-qualified defines. It then issues defines qualified by a cleared entry, with compare results chosen so that a wrongly executed write would flip each target. The aliased-destination case is driven with the two types giving opposite values, in both orders. This way a reversed priority changes the stored bit.

// File: rtl/predDefPkg.sv
package predDefPkg;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_SLT = 3'd2,
    REL_SLE = 3'd3,
    REL_SGT = 3'd4,
    REL_SGE = 3'd5,
    REL_ULT = 3'd6,
    REL_RSV = 3'd7
  } relCode_e;

  typedef enum logic [1:0] {
    WT_PLAIN    = 2'd0,
    WT_PLAIN_N  = 2'd1,
    WT_ACCUM    = 2'd2,
    WT_ACCUM_N  = 2'd3
  } writeType_e;

  // Strobes from control to the predicate storage datapath
  typedef struct packed {
    logic weA;
    logic valA;
    logic weB;
    logic valB;
  } predStrobe_t;

endpackage

// File: rtl/predCompare.sv
module predCompare
  import predDefPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        relSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              cmpTrue
);

  logic isEq;
  logic sLess;
  logic uLess;

  assign isEq  = (srcA == srcB);
  assign sLess = ($signed(srcA) < $signed(srcB));
  assign uLess = (srcA < srcB);

  always_comb begin
    unique case (relCode_e'(relSel))
      REL_EQ:  cmpTrue = isEq;
      REL_NE:  cmpTrue = !isEq;
      REL_SLT: cmpTrue = sLess;
      REL_SLE: cmpTrue = sLess || isEq;
      REL_SGT: cmpTrue = !(sLess || isEq);
      REL_SGE: cmpTrue = !sLess;
      REL_ULT: cmpTrue = uLess;
      default: cmpTrue = 1'b0;
    endcase
  end

  // R3: signed and unsigned orderings agree when the operands share a sign bit
  always_comb begin
    if (relSel == REL_SLT && srcA[DATA_W-1] == srcB[DATA_W-1])
      assert_sign_agree_R3: assert (cmpTrue == uLess);
  end

endmodule

// File: rtl/predDefCtrl.sv
module predDefCtrl
  import predDefPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        defValid,
  input  logic        qualVal,
  input  logic        cmpTrue,
  input  logic [1:0]  dstTypeA,
  input  logic [1:0]  dstTypeB,
  output predStrobe_t strobe
);

  function automatic logic [1:0] destRule(input logic [1:0] wType,
                                          input logic qual,
                                          input logic res);
    // returns {writeEnable, writeValue}
    logic [1:0] r;
    r = 2'b00;
    unique case (writeType_e'(wType))
      WT_PLAIN:   r = qual ? {1'b1, res}  : 2'b10;
      WT_PLAIN_N: r = qual ? {1'b1, !res} : 2'b10;
      WT_ACCUM:   r = (qual && res)  ? 2'b11 : 2'b00;
      WT_ACCUM_N: r = (qual && !res) ? 2'b11 : 2'b00;
      default:    r = 2'b00;
    endcase
    return r;
  endfunction

  logic [1:0] ruleA;
  logic [1:0] ruleB;

  always_comb begin
    ruleA = destRule(dstTypeA, qualVal, cmpTrue);
    ruleB = destRule(dstTypeB, qualVal, cmpTrue);
    strobe.weA  = defValid && ruleA[1];
    strobe.valA = ruleA[0];
    strobe.weB  = defValid && ruleB[1];
    strobe.valB = ruleB[0];
  end

  assert_plain_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (defValid && qualVal && dstTypeA == WT_PLAIN) |-> (strobe.weA && strobe.valA == cmpTrue));

  assert_plain_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (defValid && !qualVal && dstTypeB inside {WT_PLAIN, WT_PLAIN_N}) |-> (strobe.weB && !strobe.valB));

  assert_accum_only_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.weA && dstTypeA inside {WT_ACCUM, WT_ACCUM_N}) |-> strobe.valA);

  assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !defValid |-> !(strobe.weA || strobe.weB));

endmodule

// File: rtl/predFile.sv
module predFile
  import predDefPkg::*;
#(
  parameter int NUM_PRED = 64,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  predStrobe_t             strobe,
  input  logic [IDX_W-1:0]        dstIdxA,
  input  logic [IDX_W-1:0]        dstIdxB,
  input  logic [IDX_W-1:0]        qualIdx,
  output logic                    qualVal,
  input  logic [NUM_RD*IDX_W-1:0] rdIdx,
  output logic [NUM_RD-1:0]       rdVal
);

  localparam logic [NUM_PRED-1:0] RESET_VAL = {{(NUM_PRED-1){1'b0}}, 1'b1};

  logic [NUM_PRED-1:0] predQ;
  logic [NUM_PRED-1:0] predD;

  always_comb begin
    predD = predQ;
    if (strobe.weA && dstIdxA != '0) predD[dstIdxA] = strobe.valA;
    // second destination applied last so it wins on an alias
    if (strobe.weB && dstIdxB != '0) predD[dstIdxB] = strobe.valB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) predQ <= RESET_VAL;
    else       predQ <= predD;
  end

  assign qualVal = predQ[qualIdx];

  for (genvar k = 0; k < NUM_RD; k++) begin : gRead
    assign rdVal[k] = predQ[rdIdx[k*IDX_W +: IDX_W]];
  end

  assert_const_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    predQ[0]);

  assert_alias_second_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.weB && dstIdxA == dstIdxB && dstIdxB != '0)
      |=> (predQ[$past(dstIdxB)] == $past(strobe.valB)));

  assert_hold_when_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.weA || strobe.weB) |=> $stable(predQ));

endmodule

// File: rtl/predDefUnit.sv
module predDefUnit
  import predDefPkg::*;
#(
  parameter int NUM_PRED = 64,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    defValid,
  input  logic [2:0]              relSel,
  input  logic [IDX_W-1:0]        dstIdxA,
  input  logic [1:0]              dstTypeA,
  input  logic [IDX_W-1:0]        dstIdxB,
  input  logic [1:0]              dstTypeB,
  input  logic [IDX_W-1:0]        qualIdx,
  input  logic [DATA_W-1:0]       srcA,
  input  logic [DATA_W-1:0]       srcB,
  input  logic [NUM_RD*IDX_W-1:0] rdIdx,
  output logic [NUM_RD-1:0]       rdVal
);

  logic        cmpTrue;
  logic        qualVal;
  predStrobe_t strobe;

  predCompare #(.DATA_W(DATA_W)) i_cmp (
    .relSel (relSel),
    .srcA   (srcA),
    .srcB   (srcB),
    .cmpTrue(cmpTrue)
  );

  predDefCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .defValid(defValid),
    .qualVal (qualVal),
    .cmpTrue (cmpTrue),
    .dstTypeA(dstTypeA),
    .dstTypeB(dstTypeB),
    .strobe  (strobe)
  );

  predFile #(.NUM_PRED(NUM_PRED), .NUM_RD(NUM_RD)) i_file (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dstIdxA(dstIdxA),
    .dstIdxB(dstIdxB),
    .qualIdx(qualIdx),
    .qualVal(qualVal),
    .rdIdx  (rdIdx),
    .rdVal  (rdVal)
  );

  // R10: an operation qualified by the constant entry never takes the false-qualifier path
  assert_const_qual_R10: assert property (@(posedge clk) disable iff (!rstN)
    (qualIdx == '0) |-> qualVal);

endmodule

// File: tb/test_predDefUnit.sv
`timescale 1ns/1ps
module test_predDefUnit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        defValid;
  logic [2:0]  relSel;
  logic [5:0]  dstIdxA, dstIdxB, qualIdx;
  logic [1:0]  dstTypeA, dstTypeB;
  logic [63:0] srcA, srcB;
  logic [11:0] rdIdx;
  logic [1:0]  rdVal;

  int nChecks = 0;
  int nFails  = 0;
  bit model [64];

  always #2.5 clk = ~clk;

  predDefUnit i_predDefUnit (
    .clk(clk), .rstN(rstN), .defValid(defValid), .relSel(relSel),
    .dstIdxA(dstIdxA), .dstTypeA(dstTypeA), .dstIdxB(dstIdxB), .dstTypeB(dstTypeB),
    .qualIdx(qualIdx), .srcA(srcA), .srcB(srcB), .rdIdx(rdIdx), .rdVal(rdVal)
  );

  task automatic checkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic readPred(input int idx, output logic v);
    rdIdx[5:0]  = 6'(idx);
    rdIdx[11:6] = 6'(63 - idx);
    #0.2;
    v = rdVal[0];
  endtask

  task automatic checkEntry(input string tag, input int idx, input logic exp);
    logic v;
    readPred(idx, v);
    checkBit($sformatf("%s entry %0d", tag, idx), v, exp);
  endtask

  function automatic bit relResult(input int rel, input logic [63:0] a, input logic [63:0] b);
    case (rel)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) <  $signed(b);
      3: return $signed(a) <= $signed(b);
      4: return $signed(a) >  $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a < b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic void modelDest(input int idx, input int t, input bit q, input bit c);
    if (idx == 0) return;
    case (t)
      0: model[idx] = q ? c : 1'b0;
      1: model[idx] = q ? !c : 1'b0;
      2: if (q && c)  model[idx] = 1'b1;
      default: if (q && !c) model[idx] = 1'b1;
    endcase
  endfunction

  task automatic doDef(input int rel, input logic [63:0] a, input logic [63:0] b,
                       input int dA, input int tA, input int dB, input int tB, input int q);
    bit c, qv;
    @(negedge clk);
    relSel = 3'(rel); srcA = a; srcB = b;
    dstIdxA = 6'(dA); dstTypeA = 2'(tA); dstIdxB = 6'(dB); dstTypeB = 2'(tB);
    qualIdx = 6'(q); defValid = 1'b1;
    qv = model[q];
    c = relResult(rel, a, b);
    @(posedge clk);
    #1;
    defValid = 1'b0;
    modelDest(dA, tA, qv, c);
    modelDest(dB, tB, qv, c);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 64; i++) checkEntry(tag, i, model[i]);
  endtask

  task automatic tReset;
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    checkEntry("R1 reset", 0, 1'b1);
    checkEntry("R1 reset", 37, 1'b0);
    sweep("R1 reset");
  endtask

  task automatic tRelations;
    logic [63:0] aList [4] = '{64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd3};
    logic [63:0] bList [4] = '{64'd5, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7};
    for (int r = 0; r < 8; r++) begin
      for (int p = 0; p < 4; p++) begin
        bit e;
        e = relResult(r, aList[p], bList[p]);
        doDef(r, aList[p], bList[p], 1, 0, 2, 1, 0);
        checkEntry($sformatf("R3 R4 rel %0d pair %0d plain", r, p), 1, e);
        checkEntry($sformatf("R3 R4 rel %0d pair %0d inverted", r, p), 2, !e);
      end
    end
    // hard-coded spot checks: -1 < 1 signed, but not unsigned
    doDef(2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 0, 2, 0, 0);
    checkEntry("R3 signed lt", 1, 1'b1);
    doDef(6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 0, 2, 0, 0);
    checkEntry("R3 unsigned lt", 1, 1'b0);
    doDef(7, 64'd4, 64'd4, 1, 0, 2, 1, 0);
    checkEntry("R3 reserved code false", 1, 1'b0);
  endtask

  task automatic tAccum;
    doDef(1, 64'd0, 64'd0, 3, 0, 4, 0, 0);   // clear 3 and 4
    doDef(0, 64'd1, 64'd2, 3, 2, 4, 3, 0);   // cmp false
    checkEntry("R5 accum false keeps 0", 3, 1'b0);
    checkEntry("R5 inv accum false sets", 4, 1'b1);
    doDef(0, 64'd2, 64'd2, 3, 2, 4, 3, 0);   // cmp true
    checkEntry("R5 accum true sets", 3, 1'b1);
    checkEntry("R5 inv accum true keeps 1", 4, 1'b1);
    doDef(1, 64'd0, 64'd0, 4, 0, 9, 0, 0);   // clear 4 and 9
    doDef(0, 64'd1, 64'd2, 3, 2, 4, 2, 0);
    checkEntry("R5 accum false keeps 1", 3, 1'b1);
    checkEntry("R5 accum false keeps 0", 4, 1'b0);
  endtask

  task automatic tQualFalse;
    doDef(0, 64'd1, 64'd1, 7, 0, 8, 0, 0);   // 7=1, 8=1
    doDef(0, 64'd1, 64'd1, 9, 2, 10, 1, 0);  // 9=1, 10=0
    doDef(0, 64'd1, 64'd1, 7, 0, 10, 1, 20); // qualifier entry 20 is 0
    checkEntry("R6 plain cleared", 7, 1'b0);
    checkEntry("R6 inverted plain cleared", 10, 1'b0);
    doDef(0, 64'd1, 64'd2, 9, 3, 8, 2, 20);
    checkEntry("R7 accum unchanged", 8, 1'b1);
    checkEntry("R7 inv accum unchanged", 9, 1'b1);
    doDef(0, 64'd1, 64'd1, 7, 0, 10, 0, 8);  // qualifier entry 8 is 1
    checkEntry("R10 set qualifier executes", 7, 1'b1);
    doDef(0, 64'd1, 64'd1, 8, 0, 12, 0, 20);
    doDef(0, 64'd3, 64'd3, 13, 0, 14, 3, 8); // 8 now 0
    checkEntry("R10 cleared qualifier suppresses", 13, 1'b0);
  endtask

  task automatic tAlias;
    doDef(0, 64'd6, 64'd6, 11, 0, 11, 1, 0);
    checkEntry("R8 second wins (0)", 11, 1'b0);
    doDef(0, 64'd6, 64'd6, 11, 1, 11, 0, 0);
    checkEntry("R8 second wins (1)", 11, 1'b1);
  endtask

  task automatic tZeroTarget;
    doDef(0, 64'd1, 64'd2, 0, 0, 0, 1, 0);
    checkEntry("R2 write to entry 0", 0, 1'b1);
    doDef(0, 64'd1, 64'd1, 0, 1, 15, 0, 0);
    checkEntry("R2 entry 0 after inverted", 0, 1'b1);
    checkEntry("R2 other dest still written", 15, 1'b1);
  endtask

  task automatic tIdleAndTiming;
    logic v;
    @(negedge clk);
    relSel = 3'd0; srcA = 64'd9; srcB = 64'd9;
    dstIdxA = 6'd16; dstTypeA = 2'd0; dstIdxB = 6'd15; dstTypeB = 2'd1;
    qualIdx = 6'd0; defValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checkEntry("R9 idle no write", 16, 1'b0);
    checkEntry("R9 idle no write", 15, 1'b1);
    @(negedge clk);
    defValid = 1'b1;
    readPred(16, v);
    checkBit("R9 not visible before edge", v, 1'b0);
    @(posedge clk);
    #1;
    defValid = 1'b0;
    model[16] = 1'b1; model[15] = 1'b0;
    checkEntry("R9 visible after edge", 16, 1'b1);
    checkEntry("R9 visible after edge", 15, 1'b0);
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; defValid = 1'b0; relSel = '0; srcA = '0; srcB = '0;
    dstIdxA = '0; dstIdxB = '0; dstTypeA = '0; dstTypeB = '0; qualIdx = '0; rdIdx = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tRelations();
    tAccum();
    tQualFalse();
    tAlias();
    tZeroTarget();
    tIdleAndTiming();
    sweep("R4 final state");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule